// File: doc/BRIEF.md
# Self-Recovering Traffic Lamp Sequencer

This block is a free-running three-bit state machine that drives a green, a yellow and a red lamp. Each clock it moves one step along a fixed map of eight binary-coded states. Four of those states (2, 3, 4, 5) form the working loop, which repeats for as long as the clock runs. States 0 and 1 are power-up steps that lead into the loop. States 6 and 7 would trap each other in a useless two-state oscillation under a naive next-state design. Here the transition from 6 is steered to state 2, so no start value can keep the block out of the working loop for more than two clocks.

The lamps are registered. They are loaded from a decode of the same value that loads the state register, so on every cycle they match the state shown on the `state` port. A synchronous active-high reset returns the block to state 0. A synchronous load port can place the machine in any of the eight states, so a test can start it from every possible value.

Top module: `tl_sequencer`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next `state` is 0 and the lamps show red only.
- R2: In the working loop the state advances 2 to 3, 3 to 4, 4 to 5 and 5 to 2, one step per clock.
- R3: From state 0 the next state is 1, and from state 1 the next state is 2.
- R4: From state 7 the next state is 6, and from state 6 the next state is 2. The two states never alternate with each other.
- R5: In state 2 only the green lamp is lit, in state 3 only yellow is lit, and in states 4 and 5 only red is lit.
- R6: In states 0, 1, 6 and 7 only the red lamp is lit.
- R7: Out of reset, exactly one of `lamp_g`, `lamp_y`, `lamp_r` is high on every cycle, so green and yellow are never lit together.
- R8: With `rst` low and `load_en` high at a clock edge, the next state is `load_state`, replacing the normal step. When `rst` and `load_en` are high at the same edge, reset wins.
- R9: From any of the eight start states, the state lies in 2..5 after at most two clocks and stays in that range from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high, returns the machine to state 0 |
| load_en | input | 1 | Test load strobe: the next state is taken from `load_state` |
| load_state | input | 3 | State value to load (binary state index) |
| state | output | 3 | Current state, binary index 0..7 |
| lamp_g | output | 1 | Green lamp, registered |
| lamp_y | output | 1 | Yellow lamp, registered |
| lamp_r | output | 1 | Red lamp, registered |

## Verification
Two pairs of controls can act at the same edge. Reset and the test load can collide, and the load can also collide with the normal step of the running machine. The bench raises `rst` and `load_en` together with a non-zero load value and expects state 0 with red only. It also loads a state while the machine is running and expects the loaded value, not the successor of the old state. In both cases the lamps must stay consistent with the resulting state on the same cycle.

// File: rtl/tl_seq_pkg.sv
package tl_seq_pkg;
  localparam int unsigned ST_W   = 3;
  localparam int unsigned ST_NUM = 1 << ST_W;

  typedef logic [ST_W-1:0] st_t;

  localparam st_t ST_BOOT_A = 3'd0;
  localparam st_t ST_BOOT_B = 3'd1;
  localparam st_t ST_GO     = 3'd2;
  localparam st_t ST_WARN   = 3'd3;
  localparam st_t ST_STOP_A = 3'd4;
  localparam st_t ST_STOP_B = 3'd5;
  localparam st_t ST_TRAP_A = 3'd6;
  localparam st_t ST_TRAP_B = 3'd7;

  typedef struct packed {
    logic g;
    logic y;
    logic r;
  } lamps_t;
endpackage

// File: rtl/tl_seq_next.sv
module tl_seq_next
  import tl_seq_pkg::*;
(
  input  st_t cur,
  output st_t nxt
);
  always_comb begin
    unique case (cur)
      ST_BOOT_A: nxt = ST_BOOT_B;
      ST_BOOT_B: nxt = ST_GO;
      ST_GO:     nxt = ST_WARN;
      ST_WARN:   nxt = ST_STOP_A;
      ST_STOP_A: nxt = ST_STOP_B;
      ST_STOP_B: nxt = ST_GO;
      ST_TRAP_A: nxt = ST_GO;      // breaks the 6<->7 lockup
      ST_TRAP_B: nxt = ST_TRAP_A;
      default:   nxt = ST_BOOT_A;
    endcase
  end
endmodule

// File: rtl/tl_seq_lamp.sv
module tl_seq_lamp
  import tl_seq_pkg::*;
(
  input  st_t    st,
  output lamps_t lamps
);
  always_comb begin
    lamps = '{g: 1'b0, y: 1'b0, r: 1'b1};
    if (st == ST_GO) begin
      lamps = '{g: 1'b1, y: 1'b0, r: 1'b0};
    end else if (st == ST_WARN) begin
      lamps = '{g: 1'b0, y: 1'b1, r: 1'b0};
    end
  end
endmodule

// File: rtl/tl_seq_reg.sv
module tl_seq_reg #(
  parameter int unsigned W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) q[i] <= RST_VAL[i];
      else     q[i] <= d[i];
    end
  end
endmodule

// File: rtl/tl_sequencer.sv
module tl_sequencer
  import tl_seq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            load_en,
  input  logic [ST_W-1:0] load_state,
  output logic [ST_W-1:0] state,
  output logic            lamp_g,
  output logic            lamp_y,
  output logic            lamp_r
);
  localparam int unsigned LAMP_W = $bits(lamps_t);
  localparam logic [LAMP_W-1:0] LAMP_RST = 3'b001;

  st_t    cur_q, step_d, load_d;
  lamps_t lamp_d;
  logic [LAMP_W-1:0] lamp_q;

  tl_seq_next u_next (.cur(cur_q), .nxt(step_d));

  assign load_d = load_en ? load_state : step_d;

  // lamps decoded from the value entering the state register
  tl_seq_lamp u_lamp (.st(load_d), .lamps(lamp_d));

  tl_seq_reg #(.W(ST_W), .RST_VAL(ST_BOOT_A)) u_st_reg (
    .clk(clk), .rst(rst), .d(load_d), .q(cur_q)
  );

  tl_seq_reg #(.W(LAMP_W), .RST_VAL(LAMP_RST)) u_lamp_reg (
    .clk(clk), .rst(rst), .d(lamp_d), .q(lamp_q)
  );

  assign state  = cur_q;
  assign lamp_g = lamp_q[2];
  assign lamp_y = lamp_q[1];
  assign lamp_r = lamp_q[0];
endmodule

// File: rtl/tl_sequencer_chk.sv
module tl_sequencer_chk (
  input logic       clk,
  input logic       rst,
  input logic       load_en,
  input logic [2:0] load_state,
  input logic [2:0] state,
  input logic       lamp_g,
  input logic       lamp_y,
  input logic       lamp_r
);
  p_reset_r1: assert property (@(posedge clk) rst |=> (state == 3'd0 && lamp_r && !lamp_g && !lamp_y));
  p_loop_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!load_en && state >= 3'd2 && state <= 3'd4) |=> state == $past(state) + 3'd1);
  p_loop_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (!load_en && state == 3'd5) |=> state == 3'd2);
  p_boot_r3: assert property (@(posedge clk) disable iff (rst)
    (!load_en && state <= 3'd1) |=> state == $past(state) + 3'd1);
  p_trap_b_r4: assert property (@(posedge clk) disable iff (rst)
    (!load_en && state == 3'd7) |=> state == 3'd6);
  p_trap_a_r4: assert property (@(posedge clk) disable iff (rst)
    (!load_en && state == 3'd6) |=> state == 3'd2);
  p_green_r5: assert property (@(posedge clk) disable iff (rst) state == 3'd2 |-> lamp_g);
  p_yellow_r5: assert property (@(posedge clk) disable iff (rst) state == 3'd3 |-> lamp_y);
  p_red_r6: assert property (@(posedge clk) disable iff (rst)
    (state != 3'd2 && state != 3'd3) |-> lamp_r);
  p_one_lamp_r7: assert property (@(posedge clk) disable iff (rst)
    $countones({lamp_g, lamp_y, lamp_r}) == 1);
  p_load_r8: assert property (@(posedge clk) disable iff (rst)
    load_en |=> state == $past(load_state));
endmodule

bind tl_sequencer tl_sequencer_chk u_chk (
  .clk(clk), .rst(rst), .load_en(load_en), .load_state(load_state),
  .state(state), .lamp_g(lamp_g), .lamp_y(lamp_y), .lamp_r(lamp_r)
);

// File: tb/tb_tl_sequencer.sv
module tb_tl_sequencer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load_en = 1'b0;
  logic [2:0] load_state = 3'd0;
  logic [2:0] state;
  logic lamp_g, lamp_y, lamp_r;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tl_sequencer dut (
    .clk(clk), .rst(rst), .load_en(load_en), .load_state(load_state),
    .state(state), .lamp_g(lamp_g), .lamp_y(lamp_y), .lamp_r(lamp_r)
  );

  // vector: {state, expected next, g, y, r}
  localparam logic [8:0] VEC [8] = '{
    {3'd0, 3'd1, 3'b001}, {3'd1, 3'd2, 3'b001},
    {3'd2, 3'd3, 3'b100}, {3'd3, 3'd4, 3'b010},
    {3'd4, 3'd5, 3'b001}, {3'd5, 3'd2, 3'b001},
    {3'd6, 3'd2, 3'b001}, {3'd7, 3'd6, 3'b001}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] lamps_of(input logic [2:0] s);
    for (int k = 0; k < 8; k++) if (VEC[k][8:6] == s) return VEC[k][2:0];
    return 3'b000;
  endfunction

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    check("R1 reset", {state, lamp_g, lamp_y, lamp_r}, {3'd0, 3'b001});
    rst = 1'b0;
    // table walk: each state loaded, then one free step
    for (int i = 0; i < 8; i++) begin
      load_en = 1'b1; load_state = VEC[i][8:6];
      tick();
      check("R8 load", {3'd0, state}, {3'd0, VEC[i][8:6]});
      check(i inside {2,3,4,5} ? "R5 lamps" : "R6 lamps",
            {3'd0, lamp_g, lamp_y, lamp_r}, {3'd0, VEC[i][2:0]});
      load_en = 1'b0;
      tick();
      check(i inside {2,3,4,5} ? "R2 step" : (i < 2 ? "R3 step" : "R4 step"),
            {3'd0, state}, {3'd0, VEC[i][5:3]});
    end
    // every start: 10 free clocks, in loop by the second, lamps one-hot
    for (int s = 0; s < 8; s++) begin
      logic [2:0] model;
      model = 3'(s);
      load_en = 1'b1; load_state = 3'(s);
      tick();
      load_en = 1'b0;
      for (int c = 1; c <= 10; c++) begin
        tick();
        for (int k = 0; k < 8; k++) if (VEC[k][8:6] == model) begin
          model = VEC[k][5:3];
          break;
        end
        check("R9 path", {3'd0, state}, {3'd0, model});
        if (c >= 2) check("R9 in loop", {5'd0, (state >= 3'd2 && state <= 3'd5)}, 6'd1);
        check("R7 one lamp", {4'd0, 2'($countones({lamp_g, lamp_y, lamp_r}))}, 6'd1);
        check("R5 R6 lamps", {3'd0, lamp_g, lamp_y, lamp_r}, {3'd0, lamps_of(model)});
      end
    end
    // reset and load at the same edge
    rst = 1'b1; load_en = 1'b1; load_state = 3'd3;
    tick();
    check("R8 reset wins", {state, lamp_g, lamp_y, lamp_r}, {3'd0, 3'b001});
    check("R1 reset mid run", {3'd0, lamp_g, lamp_y, lamp_r}, 6'b000001);
    // load overrides the running step
    rst = 1'b0; load_en = 1'b0;
    tick(); tick();
    check("R3 boot", {3'd0, state}, 6'd2);
    load_en = 1'b1; load_state = 3'd7;
    tick();
    check("R8 load over step", {state, lamp_g, lamp_y, lamp_r}, {3'd7, 3'b001});
    load_en = 1'b0;
    tick();
    check("R4 trap b", {3'd0, state}, 6'd6);
    tick();
    check("R4 exit", {state, lamp_g, lamp_y, lamp_r}, {3'd2, 3'b100});
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule